// File: doc/BRIEF.md
# x87 Escape Opcode Decoder

This block is the first decode step for floating-point escape instructions. Each cycle it takes an opcode byte and the ModRM byte that follows it. It decides whether the opcode belongs to the eight-byte floating-point escape group. If it does, the block classifies the operation and the operand form. The result is presented one clock later through a single register stage.

Decoding runs in two levels. The first level matches the fixed five-bit escape prefix. The second level combines the low three opcode bits (the row) with the ModRM reg field. Only row 0 decodes the full arithmetic table. The other recognised rows report a generic escape class. A row whose bit is clear in the `KnownRows` parameter has no table entry and is flagged as undefined. By default only row 7 is left unmapped.

The operand form comes from the ModRM mod field. In register form the stack index is taken from ModRM r/m. Memory form is reported with an extra flag for the instruction-pointer-relative encoding.

Top module: `x87_esc_decoder`

## Requirements
- R1: An opcode is an escape only when its top five bits are 5'b11011, that is 0xD8 to 0xDF. For any other opcode, outValid and every other output are 0 in the following cycle.
- R2: For row 0 (opcode 0xD8), opClass follows ModRM reg as listed here. reg 0 gives 1 (add), reg 1 gives 2 (multiply), reg 2 gives 3 (compare), reg 3 gives 4 (compare and pop), reg 4 gives 5 (subtract), reg 5 gives 6 (reverse subtract), reg 6 gives 7 (divide), and reg 7 gives 8 (reverse divide).
- R3: For rows 1 to 6, opClass is 9 (generic escape) whatever the reg field holds, and undefFlag is 0.
- R4: For row 7, with the default `KnownRows` of 8'h7F, undefFlag is 1, opClass is 0 and outValid is 1.
- R5: When ModRM mod (bits 7:6) is 2'b11, isReg is 1 and stIdx equals ModRM r/m (bits 2:0).
- R6: For any other mod value, isReg is 0 and stIdx is 0.
- R7: ripRel is 1 exactly when mod is 2'b00 and r/m is 3'b101.
- R8: Results appear one clock after the inputs are sampled. When inValid is 0, all outputs are 0 in the following cycle.
- R9: While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The opcode and ModRM bytes are valid this cycle |
| opByte | input | 8 | Opcode byte |
| modrm | input | 8 | ModRM byte |
| outValid | output | 1 | A valid escape was decoded |
| opClass | output | 4 | Operation class code |
| isReg | output | 1 | Register operand form |
| stIdx | output | 3 | Stack register index (register form) |
| ripRel | output | 1 | Memory operand is instruction-pointer relative |
| undefFlag | output | 1 | Escape row has no table entry |

## Verification
Every result of this block passes through the one output register, so each result is due exactly one rising edge after its inputs are applied. The bench drives the inputs on the falling edge. It then waits through one rising edge and compares all outputs at the next falling edge, which is when the captured decode is stable. Because new inputs are driven only after that comparison, every sample belongs to exactly one stimulus. This holds for the inValid-low and non-escape cases as well.

// File: rtl/x87dec_pkg.sv
package x87dec_pkg;

  localparam int OpW    = 8;
  localparam int ClassW = 4;
  localparam int IdxW   = 3;
  localparam logic [4:0] EscPrefix = 5'b11011;

  typedef enum logic [ClassW-1:0] {
    CLS_NONE    = 4'd0,
    CLS_ADD     = 4'd1,
    CLS_MUL     = 4'd2,
    CLS_CMP     = 4'd3,
    CLS_CMPPOP  = 4'd4,
    CLS_SUB     = 4'd5,
    CLS_SUBREV  = 4'd6,
    CLS_DIV     = 4'd7,
    CLS_DIVREV  = 4'd8,
    CLS_GENERIC = 4'd9
  } opClass_e;

  typedef struct packed {
    logic load;
    logic fullTable;
    logic undef;
    logic regForm;
    logic ripRel;
  } decStrobe_t;

endpackage

// File: rtl/x87dec_ctrl.sv
module x87dec_ctrl
  import x87dec_pkg::*;
#(
  parameter logic [7:0] KnownRows = 8'h7F
) (
  input  logic           inValid,
  input  logic [OpW-1:0] opByte,
  input  logic [OpW-1:0] modrm,
  output decStrobe_t     strobe
);

  logic       escHit;
  logic [2:0] row;
  logic [1:0] modField;
  logic [2:0] rmField;

  assign escHit   = (opByte[7:3] == EscPrefix);
  assign row      = opByte[2:0];
  assign modField = modrm[7:6];
  assign rmField  = modrm[2:0];

  always_comb begin
    strobe           = '0;
    strobe.load      = inValid && escHit;
    strobe.fullTable = (row == 3'd0);
    strobe.undef     = !KnownRows[row];
    strobe.regForm   = (modField == 2'b11);
    strobe.ripRel    = (modField == 2'b00) && (rmField == 3'b101);
  end

  // R1: a load is only ever requested for an opcode inside 0xD8..0xDF
  always_comb begin
    if (strobe.load) begin
      a_r1_load_in_range: assert (opByte >= 8'hD8 && opByte <= 8'hDF);
    end
  end

endmodule

// File: rtl/x87dec_dpath.sv
module x87dec_dpath
  import x87dec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  decStrobe_t        strobe,
  input  logic              inValid,
  input  logic [OpW-1:0]    opByte,
  input  logic [OpW-1:0]    modrm,
  output logic              outValid,
  output logic [ClassW-1:0] opClass,
  output logic              isReg,
  output logic [IdxW-1:0]   stIdx,
  output logic              ripRel,
  output logic              undefFlag
);

  logic [2:0]        regField;
  logic [ClassW-1:0] arithClass;
  logic [ClassW-1:0] nextClass;

  assign regField = modrm[5:3];

  always_comb begin
    unique case (regField)
      3'd0: arithClass = CLS_ADD;
      3'd1: arithClass = CLS_MUL;
      3'd2: arithClass = CLS_CMP;
      3'd3: arithClass = CLS_CMPPOP;
      3'd4: arithClass = CLS_SUB;
      3'd5: arithClass = CLS_SUBREV;
      3'd6: arithClass = CLS_DIV;
      default: arithClass = CLS_DIVREV;
    endcase
  end

  always_comb begin
    if (strobe.undef)          nextClass = CLS_NONE;
    else if (strobe.fullTable) nextClass = arithClass;
    else                       nextClass = CLS_GENERIC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      opClass   <= '0;
      isReg     <= 1'b0;
      stIdx     <= '0;
      ripRel    <= 1'b0;
      undefFlag <= 1'b0;
    end else if (strobe.load) begin
      outValid  <= 1'b1;
      opClass   <= nextClass;
      isReg     <= strobe.regForm;
      stIdx     <= strobe.regForm ? modrm[2:0] : '0;
      ripRel    <= strobe.ripRel;
      undefFlag <= strobe.undef;
    end else begin
      outValid  <= 1'b0;
      opClass   <= '0;
      isReg     <= 1'b0;
      stIdx     <= '0;
      ripRel    <= 1'b0;
      undefFlag <= 1'b0;
    end
  end

  // R8: a valid escape in one cycle gives outValid in the next
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opByte[7:3] == 5'b11011) |=> outValid);

  // R1: a non-escape opcode leaves all outputs clear
  a_r1_zero_outside: assert property (@(posedge clk) disable iff (!rstN)
    (opByte[7:3] != 5'b11011) |=> (!outValid && opClass == '0 && !isReg
                                   && stIdx == '0 && !ripRel && !undefFlag));

  // R2: row 0 never yields an undefined or generic class
  a_r2_row0_arith: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opByte == 8'hD8) |=> (!undefFlag && opClass >= 4'd1 && opClass <= 4'd8));

  // R4: an undefined result carries no class but is still a valid escape
  a_r4_undef_noclass: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> (outValid && opClass == '0));

  // R5: register form follows mod 2'b11
  a_r5_reg_form: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opByte[7:3] == 5'b11011 && modrm[7:6] == 2'b11)
      |=> (isReg && stIdx == $past(modrm[2:0])));

  // R7: pointer-relative operands never come with a register form
  a_r7_rip_mem_only: assert property (@(posedge clk) disable iff (!rstN)
    ripRel |-> (!isReg && outValid));

endmodule

// File: rtl/x87_esc_decoder.sv
module x87_esc_decoder
  import x87dec_pkg::*;
#(
  parameter logic [7:0] KnownRows = 8'h7F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  opByte,
  input  logic [7:0]  modrm,
  output logic        outValid,
  output logic [3:0]  opClass,
  output logic        isReg,
  output logic [2:0]  stIdx,
  output logic        ripRel,
  output logic        undefFlag
);

  decStrobe_t strobe;

  x87dec_ctrl #(.KnownRows(KnownRows)) uCtrl (
    .inValid (inValid),
    .opByte  (opByte),
    .modrm   (modrm),
    .strobe  (strobe)
  );

  x87dec_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inValid   (inValid),
    .opByte    (opByte),
    .modrm     (modrm),
    .outValid  (outValid),
    .opClass   (opClass),
    .isReg     (isReg),
    .stIdx     (stIdx),
    .ripRel    (ripRel),
    .undefFlag (undefFlag)
  );

endmodule

// File: tb/x87_esc_decoder_test.sv
module x87_esc_decoder_test;

  localparam int ClkPeriod = 10;
  localparam int MaxCycles = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic [7:0] modrm = 8'h00;
  logic       outValid;
  logic [3:0] opClass;
  logic       isReg;
  logic [2:0] stIdx;
  logic       ripRel;
  logic       undefFlag;

  int checks = 0;
  int fails = 0;

  always #(ClkPeriod/2) clk = ~clk;

  x87_esc_decoder uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opByte(opByte), .modrm(modrm),
    .outValid(outValid), .opClass(opClass), .isReg(isReg), .stIdx(stIdx),
    .ripRel(ripRel), .undefFlag(undefFlag)
  );

  // packed result: {outValid, opClass[3:0], isReg, stIdx[2:0], ripRel, undefFlag}
  function automatic logic [10:0] expect_of(input logic v, input logic [7:0] op,
                                            input logic [7:0] m);
    logic [3:0] cls;
    logic       reg_f, rip, und;
    logic [2:0] idx;
    if (!v || op[7:3] != 5'b11011) return 11'd0;
    und = (op[2:0] == 3'd7);
    if (und)                 cls = 4'd0;
    else if (op[2:0] == 3'd0) cls = 4'(m[5:3]) + 4'd1;
    else                     cls = 4'd9;
    reg_f = (m[7:6] == 2'b11);
    idx   = reg_f ? m[2:0] : 3'd0;
    rip   = (m[7:6] == 2'b00) && (m[2:0] == 3'b101);
    return {1'b1, cls, reg_f, idx, rip, und};
  endfunction

  function automatic logic [10:0] actual();
    return {outValid, opClass, isReg, stIdx, ripRel, undefFlag};
  endfunction

  task automatic check(input string req, input logic [10:0] exp);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (op %h modrm %h v %b)",
               req, actual(), exp, opByte, modrm, inValid);
    end
  endtask

  // drive at the falling edge, result due after one rising edge, sample at the next falling edge
  task automatic step(input string req, input logic v, input logic [7:0] op,
                      input logic [7:0] m);
    inValid = v;
    opByte  = op;
    modrm   = m;
    @(posedge clk);
    @(negedge clk);
    check(req, expect_of(v, op, m));
  endtask

  initial begin
    #(ClkPeriod * MaxCycles);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    inValid = 1'b1;
    opByte  = 8'hD8;
    modrm   = 8'hC1;
    repeat (3) @(negedge clk);
    check("R9 reset", 11'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 first result", expect_of(1'b1, 8'hD8, 8'hC1));

    for (int r = 0; r < 8; r++) begin
      step("R2 row0 reg table", 1'b1, 8'hD8, {2'b11, 3'(r), 3'(7 - r)});
    end
    for (int r = 0; r < 8; r++) begin
      step("R2 row0 memory", 1'b1, 8'hD8, {2'b01, 3'(r), 3'd4});
    end
    for (int w = 1; w < 7; w++) begin
      step("R3 generic rows", 1'b1, 8'hD8 + 8'(w), {2'b10, 3'(w), 3'd2});
    end
    step("R4 row7 undefined", 1'b1, 8'hDF, 8'hC3);
    step("R4 row7 memory", 1'b1, 8'hDF, 8'h05);
    step("R1 below range", 1'b1, 8'hD7, 8'hC0);
    step("R1 above range", 1'b1, 8'hE0, 8'hC0);
    step("R1 zero opcode", 1'b1, 8'h00, 8'h05);
    step("R5 reg form st7", 1'b1, 8'hD8, 8'hE7);
    step("R6 mem form mod10", 1'b1, 8'hD8, 8'h87);
    step("R7 rip relative", 1'b1, 8'hD8, 8'h25);
    step("R7 mod01 r/m101 not rip", 1'b1, 8'hD8, 8'h65);
    step("R8 invalid input", 1'b0, 8'hD8, 8'hC1);
    step("R8 recover", 1'b1, 8'hDA, 8'hD9);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      logic [7:0] m;
      logic       v;
      op = 8'($urandom);
      if ($urandom % 4 != 0) op = {5'b11011, 3'($urandom)};
      m = 8'($urandom);
      v = ($urandom % 8) != 0;
      step("R1 R2 R3 R5 R6 R7 random", v, op, m);
    end

    rstN = 1'b0;
    #1;
    check("R9 async reset", 11'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule